// File: doc/BRIEF.md
# Time-Triggered Scheduled-Traffic Fetch Controller

This block decides when frames of the scheduled traffic class are pulled from memory for transmission. Software fills a small table of streams. Each entry names a stream by its destination MAC address and VLAN ID, and gives a trigger time in nanoseconds measured from the start of the gate cycle, plus a count of 1 to 4 frames to fetch at that trigger. The block follows the gate cycle through a cycle-start pulse and the running offset within the cycle. It checks the scheduled-class gate, and it raises fetch requests tagged with the stream index, frame count, MAC address and VLAN ID.

The block has two operating modes. While the table holds no stream, it runs in a continuous loop and requests one scheduled frame on every clock. As soon as any stream is valid, it switches to discrete operation. In discrete operation a pointer walks the entries in index order and stops at each one until the cycle offset reaches that entry's trigger. The entry then fires if the gate is open, or else is counted as skipped; either way the pointer moves on, so each entry is handled at most once per cycle. Entries whose trigger is not below the cycle time are flagged and passed over. Nothing happens while no valid gate schedule is active.

Top module: `tt_fetch_ctrl`

## Requirements
- R1: After reset fetch_req is 0, mode_disc is 0 and skip_cnt is 0.
- R2: While sched_active is 0, fetch_req stays 0 in every cycle.
- R3: While sched_active is 1 and no entry is valid, fetch_req is 1 on every clock, with fetch_idx 0 and fetch_cnt 1. The first request appears one clock after these conditions hold.
- R4: A write with cfg_en=1 and cfg_cnt in 1..4 stores the MAC, VLAN ID, trigger and count at cfg_idx and marks the entry valid. A write with cfg_en=0 makes that entry invalid. mode_disc is 1 exactly when at least one entry is valid.
- R5: A write with cfg_en=1 and cfg_cnt of 0 or 5..7 is rejected and leaves the entry unchanged. Every request carries a count in 1..4.
- R6: In discrete mode, the entry under the pointer fires when cyc_ofs >= its trigger and gate_open is 1 at a clock edge. fetch_req is then 1 for one cycle after that edge, with that entry's index, count, MAC address and VLAN ID.
- R7: If the trigger is reached while gate_open is 0, no request is made and skip_cnt rises by 1 (saturating). The entry is not retried later in the same cycle, even if the gate opens.
- R8: A cyc_start pulse returns the pointer to entry 0, so entries fire again in the next cycle. Without it, no entry fires twice.
- R9: Entries that share a trigger fire in ascending index order, on consecutive clocks.
- R10: cfg_err bit i is 1 when entry i is valid and its trigger is >= cycle_time. Such an entry never fires and is not counted as skipped.
- R11: At a clock edge where cyc_start is 1, no discrete request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_en | input | 1 | 1 adds or overwrites an entry, 0 removes it |
| cfg_idx | input | clog2(N_STREAMS) | Entry index to write |
| cfg_mac | input | 48 | Destination MAC address of the stream |
| cfg_vid | input | 12 | VLAN ID of the stream |
| cfg_trig | input | 32 | Trigger offset in ns from cycle start |
| cfg_cnt | input | 3 | Frames per trigger, legal 1..4 |
| cycle_time | input | 32 | Gate cycle length in ns |
| sched_active | input | 1 | A valid gate schedule is running |
| cyc_start | input | 1 | One-clock pulse at gate-cycle start |
| cyc_ofs | input | 32 | Current offset within the cycle in ns |
| gate_open | input | 1 | Scheduled-class gate is open |
| fetch_req | output | 1 | Fetch request, one clock per request |
| fetch_idx | output | clog2(N_STREAMS) | Stream index of the request |
| fetch_cnt | output | 3 | Frames to fetch |
| fetch_mac | output | 48 | Destination MAC of the request |
| fetch_vid | output | 12 | VLAN ID of the request |
| mode_disc | output | 1 | 1 in discrete mode, 0 in continuous mode |
| cfg_err | output | N_STREAMS | Per-entry trigger-beyond-cycle flag |
| skip_cnt | output | SKIP_W | Triggers missed with the gate closed |

## Verification
The bench targets triggers that tie. A design that evaluated two entries in one clock, or that reordered them, would show a merged or swapped index at the output. It closes the gate exactly at a trigger and then reopens it. A design that retried the entry would emit a late request, and one that forgot the skip would leave skip_cnt at zero. It raises cyc_start while the offset already lies past every trigger, which catches a design that fires in the restart cycle itself. It also programs a trigger beyond the cycle time, rejects out-of-range counts, and empties the table again to confirm that continuous mode comes back, so that a wrong mode decode or a rejected write that slipped through shows up at the ports.

// File: rtl/tt_fetch_pkg.sv
// Package: shared constants and the stream entry type for the
// time-triggered fetch controller. Assumes fixed field widths for the
// MAC address, VLAN ID, offset and count.
package tt_fetch_pkg;
    localparam int MAC_W   = 48;
    localparam int VID_W   = 12;
    localparam int OFS_W   = 32;
    localparam int CNT_W   = 3;
    localparam int CNT_MAX = 4;

    typedef struct packed {
        logic             valid;
        logic [MAC_W-1:0] mac;
        logic [VID_W-1:0] vid;
        logic [OFS_W-1:0] trig;
        logic [CNT_W-1:0] cnt;
    } stream_ent_t;
endpackage

// File: rtl/tt_stream_table.sv
// Stream table: holds N entries written by software, rejects adds
// whose count lies outside 1..CNT_MAX, and flags entries whose trigger
// is not below the cycle time. Assumes one write per clock.
module tt_stream_table
    import tt_fetch_pkg::*;
#(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              en,
    input  logic [IW-1:0]     idx,
    input  logic [MAC_W-1:0]  mac,
    input  logic [VID_W-1:0]  vid,
    input  logic [OFS_W-1:0]  trig,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [OFS_W-1:0]  cycle_time,
    output stream_ent_t       ents [N],
    output logic [N-1:0]      err,
    output logic              any_valid
);
    logic          cnt_ok;
    logic          bad_wr;
    logic [N-1:0]  valid_vec;

    // Count legality of the incoming add
    assign cnt_ok = (cnt != '0) && (cnt <= CNT_W'(CNT_MAX));
    assign bad_wr = we && en && !cnt_ok;

    generate
        for (genvar i = 0; i < N; i++) begin : g_ent
            // Entry storage with reject on illegal count
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ents[i] <= '0;
                end else if (we && (idx == IW'(i))) begin
                    if (!en) begin
                        ents[i].valid <= 1'b0;
                    end else if (cnt_ok) begin
                        ents[i] <= '{valid: 1'b1, mac: mac, vid: vid,
                                     trig: trig, cnt: cnt};
                    end
                end
            end
            // Per-entry flag for a trigger at or past the cycle end
            assign err[i]       = ents[i].valid && (ents[i].trig >= cycle_time);
            assign valid_vec[i] = ents[i].valid;
        end
    endgenerate

    // Mode source: any stream programmed
    assign any_valid = |valid_vec;

    AST_REJ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bad_wr) |-> $stable(valid_vec)); // R5
endmodule

// File: rtl/tt_trigger_walk.sv
// Trigger walker: in continuous mode requests every clock; in discrete
// mode steps a pointer through the entries, firing each one once per
// gate cycle when its trigger is reached with the gate open, else
// counting a skip. Assumes valid entries are ordered by ascending
// trigger in index order.
module tt_trigger_walk
    import tt_fetch_pkg::*;
#(
    parameter int N      = 4,
    parameter int SKIP_W = 16,
    localparam int IW    = $clog2(N),
    localparam int PW    = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stream_ent_t       ents [N],
    input  logic [N-1:0]      err,
    input  logic              any_valid,
    input  logic [OFS_W-1:0]  cycle_time,
    input  logic              sched_active,
    input  logic              cyc_start,
    input  logic [OFS_W-1:0]  cyc_ofs,
    input  logic              gate_open,
    output logic              fire_q,
    output logic [IW-1:0]     idx_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [MAC_W-1:0]  mac_q,
    output logic [VID_W-1:0]  vid_q,
    output logic [SKIP_W-1:0] skip_q
);
    logic [PW-1:0] ptr;
    logic          ptr_done;
    logic          cont_q;
    stream_ent_t   sel;
    logic          sel_err;

    // Entry currently under the pointer
    assign ptr_done = (ptr >= PW'(N));
    assign sel      = ents[ptr[IW-1:0]];
    assign sel_err  = err[ptr[IW-1:0]];

    // Pointer walk, request generation and skip counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            fire_q <= 1'b0;
            cont_q <= 1'b0;
            idx_q  <= '0;
            cnt_q  <= '0;
            mac_q  <= '0;
            vid_q  <= '0;
            skip_q <= '0;
        end else begin
            fire_q <= 1'b0;
            cont_q <= 1'b0;
            if (!sched_active) begin
                ptr <= '0;
            end else if (!any_valid) begin
                ptr    <= '0;
                fire_q <= 1'b1;
                cont_q <= 1'b1;
                idx_q  <= '0;
                cnt_q  <= CNT_W'(1);
                mac_q  <= '0;
                vid_q  <= '0;
            end else if (cyc_start) begin
                ptr <= '0;
            end else if (!ptr_done) begin
                if (!sel.valid || sel_err) begin
                    ptr <= ptr + PW'(1);
                end else if (cyc_ofs >= sel.trig) begin
                    ptr <= ptr + PW'(1);
                    if (gate_open) begin
                        fire_q <= 1'b1;
                        idx_q  <= ptr[IW-1:0];
                        cnt_q  <= sel.cnt;
                        mac_q  <= sel.mac;
                        vid_q  <= sel.vid;
                    end else if (skip_q != '1) begin
                        skip_q <= skip_q + SKIP_W'(1);
                    end
                end
            end
        end
    end

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(sched_active) |-> !fire_q); // R2
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> (cnt_q != '0) && (cnt_q <= CNT_W'(CNT_MAX))); // R5
    AST_GATE_AT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && fire_q && !cont_q |-> $past(gate_open)); // R6
    AST_SKIP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> skip_q >= $past(skip_q)); // R7
    AST_NO_ERR_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && fire_q && !cont_q |-> $past(sel.trig < cycle_time)); // R10
    AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cyc_start) && $past(any_valid) |-> !fire_q); // R11
endmodule

// File: rtl/tt_fetch_ctrl.sv
// Top: time-triggered fetch controller for scheduled traffic. Joins
// the stream table and the trigger walker. Assumes cyc_ofs counts from
// 0 after each cyc_start and that software orders valid entries by
// ascending trigger.
module tt_fetch_ctrl
    import tt_fetch_pkg::*;
#(
    parameter int N_STREAMS = 4,
    parameter int SKIP_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic                         cfg_en,
    input  logic [$clog2(N_STREAMS)-1:0] cfg_idx,
    input  logic [47:0]                  cfg_mac,
    input  logic [11:0]                  cfg_vid,
    input  logic [31:0]                  cfg_trig,
    input  logic [2:0]                   cfg_cnt,
    input  logic [31:0]                  cycle_time,
    input  logic                         sched_active,
    input  logic                         cyc_start,
    input  logic [31:0]                  cyc_ofs,
    input  logic                         gate_open,
    output logic                         fetch_req,
    output logic [$clog2(N_STREAMS)-1:0] fetch_idx,
    output logic [2:0]                   fetch_cnt,
    output logic [47:0]                  fetch_mac,
    output logic [11:0]                  fetch_vid,
    output logic                         mode_disc,
    output logic [N_STREAMS-1:0]         cfg_err,
    output logic [SKIP_W-1:0]            skip_cnt
);
    stream_ent_t ents [N_STREAMS];
    logic        any_valid;

    tt_stream_table #(.N(N_STREAMS)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .en         (cfg_en),
        .idx        (cfg_idx),
        .mac        (cfg_mac),
        .vid        (cfg_vid),
        .trig       (cfg_trig),
        .cnt        (cfg_cnt),
        .cycle_time (cycle_time),
        .ents       (ents),
        .err        (cfg_err),
        .any_valid  (any_valid)
    );

    tt_trigger_walk #(.N(N_STREAMS), .SKIP_W(SKIP_W)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .ents         (ents),
        .err          (cfg_err),
        .any_valid    (any_valid),
        .cycle_time   (cycle_time),
        .sched_active (sched_active),
        .cyc_start    (cyc_start),
        .cyc_ofs      (cyc_ofs),
        .gate_open    (gate_open),
        .fire_q       (fetch_req),
        .idx_q        (fetch_idx),
        .cnt_q        (fetch_cnt),
        .mac_q        (fetch_mac),
        .vid_q        (fetch_vid),
        .skip_q       (skip_cnt)
    );

    // Mode output follows table occupancy
    assign mode_disc = any_valid;
endmodule

// File: tb/sim_tt_fetch_ctrl.sv
module sim_tt_fetch_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_en = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [47:0] cfg_mac = '0;
    logic [11:0] cfg_vid = '0;
    logic [31:0] cfg_trig = '0;
    logic [2:0]  cfg_cnt = '0;
    logic [31:0] cycle_time = 32'd1000;
    logic        sched_active = 1'b0, cyc_start = 1'b0, gate_open = 1'b0;
    logic [31:0] cyc_ofs = '0;
    logic        fetch_req, mode_disc;
    logic [1:0]  fetch_idx;
    logic [2:0]  fetch_cnt;
    logic [47:0] fetch_mac;
    logic [11:0] fetch_vid;
    logic [3:0]  cfg_err;
    logic [15:0] skip_cnt;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tt_fetch_ctrl u0 (.*);

    task automatic cyc();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] i, logic en, logic [47:0] m, logic [11:0] v,
                      logic [31:0] t, logic [2:0] c);
        cfg_we = 1; cfg_en = en; cfg_idx = i; cfg_mac = m; cfg_vid = v;
        cfg_trig = t; cfg_cnt = c;
        cyc();
        cfg_we = 0;
    endtask

    task automatic chk_fire(string req, logic [1:0] i, logic [2:0] c,
                            logic [47:0] m, logic [11:0] v);
        chk(req, fetch_req, 1);
        chk(req, fetch_idx, i);
        chk(req, fetch_cnt, c);
        chk(req, fetch_mac, m);
        chk(req, fetch_vid, v);
    endtask

    task automatic t_reset();
        chk("R1 req", fetch_req, 0);
        chk("R1 mode", mode_disc, 0);
        chk("R1 skip", skip_cnt, 0);
    endtask

    task automatic t_idle();
        sched_active = 0;
        for (int k = 0; k < 3; k++) begin cyc(); chk("R2 idle", fetch_req, 0); end
    endtask

    task automatic t_continuous();
        sched_active = 1;
        cyc();
        chk_fire("R3 cont", 0, 1, 0, 0);
        cyc();
        chk("R3 cont again", fetch_req, 1);
        chk("R3 mode", mode_disc, 0);
    endtask

    task automatic t_reject();
        wr(0, 1, 48'hA, 12'd1, 32'd10, 3'd0);
        wr(0, 1, 48'hA, 12'd1, 32'd10, 3'd5);
        chk("R5 rej mode", mode_disc, 0);
        chk("R5 rej still cont", fetch_req, 1);
    endtask

    task automatic t_program();
        sched_active = 0;
        wr(0, 1, 48'h0A35_0001_0E00, 12'd10, 32'd100, 3'd2);
        wr(1, 1, 48'h0A35_0001_0F00, 12'd20, 32'd200, 3'd1);
        wr(2, 1, 48'h0A35_0002_0000, 12'd30, 32'd200, 3'd4);
        wr(3, 1, 48'h0A35_0003_0000, 12'd40, 32'd5000, 3'd3);
        chk("R4 mode disc", mode_disc, 1);
        chk("R10 err flag", cfg_err, 4'b1000);
    endtask

    task automatic t_discrete();
        sched_active = 1; cyc_start = 1; cyc_ofs = 0; gate_open = 1;
        cyc();
        cyc_start = 0; cyc_ofs = 50;
        cyc();
        chk("R6 before trig", fetch_req, 0);
        cyc_ofs = 100;
        cyc();
        chk_fire("R6 fire e0", 0, 2, 48'h0A35_0001_0E00, 12'd10);
        cyc();
        chk("R8 no repeat", fetch_req, 0);
        cyc_ofs = 200;
        cyc();
        chk_fire("R9 tie first", 1, 1, 48'h0A35_0001_0F00, 12'd20);
        cyc();
        chk_fire("R9 tie second", 2, 4, 48'h0A35_0002_0000, 12'd30);
        cyc_ofs = 999;
        for (int k = 0; k < 4; k++) begin
            cyc();
            chk("R10 err never fires", fetch_req, 0);
        end
        chk("R10 no skip", skip_cnt, 0);
    endtask

    task automatic t_gate_closed();
        cyc_start = 1; cyc_ofs = 0; gate_open = 0;
        cyc();
        cyc_start = 0; cyc_ofs = 100;
        cyc();
        chk("R7 no fire", fetch_req, 0);
        chk("R7 skip", skip_cnt, 1);
        gate_open = 1; cyc_ofs = 150;
        cyc();
        chk("R7 no retry", fetch_req, 0);
        cyc();
        chk("R7 no retry later", fetch_req, 0);
    endtask

    task automatic t_restart();
        cyc_ofs = 300; cyc_start = 1; gate_open = 1;
        cyc();
        chk("R11 start quiet", fetch_req, 0);
        cyc_start = 0;
        cyc();
        chk_fire("R8 refire e0", 0, 2, 48'h0A35_0001_0E00, 12'd10);
        cyc();
        chk("R9 order e1", fetch_idx, 1);
        cyc();
        chk("R9 order e2", fetch_idx, 2);
        cyc();
        chk("R8 end", fetch_req, 0);
        chk("R7 skip held", skip_cnt, 1);
    endtask

    task automatic t_empty_again();
        for (int i = 0; i < 4; i++) wr(2'(i), 0, 0, 0, 0, 0);
        chk("R4 mode back", mode_disc, 0);
        chk("R4 err cleared", cfg_err, 0);
        cyc();
        chk_fire("R3 cont resumes", 0, 1, 0, 0);
        sched_active = 0;
        cyc();
        chk("R2 idle end", fetch_req, 0);
    endtask

    initial begin
        @(negedge clk); cyc(); cyc();
        rst_n = 1;
        cyc();
        t_reset();
        t_idle();
        t_continuous();
        t_reject();
        t_program();
        t_discrete();
        t_gate_closed();
        t_restart();
        t_empty_again();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule